// File: doc/BRIEF.md
# Flash-to-RAM Emulation Address Overlay

This block holds a small control register and an address remapper. Together they let a fixed 4 KB window of on-chip RAM take the place of one 4 KB flash block, so software can rehearse flash reprogramming in real time on RAM. One enable bit and a three-bit block number pick which of the eight lowest 4 KB flash blocks is overlaid. Every CPU address presented to the block comes out either unchanged or redirected into the RAM window, with the offset inside the block kept.

While the overlay is enabled, all of flash is protected against write and erase. A write that reaches flash in that state is flagged. A mode input tells the block whether on-chip ROM is in use. When ROM is off, the enable bit has no effect at all.

The register is cleared by power-on reset and on entry to either standby mode. A manual reset leaves it intact and blocks register writes while it is held. The access in the cycle right after a register write may see either mapping and is treated as undefined.

Top module: `flash_ram_overlay`

## Requirements
- R1: A register write with `rst_man_n` high and no standby request loads `reg_wdata[3:0]` on the next clock edge. `reg_rdata[3]` is the enable bit and `reg_rdata[2:0]` is the block number.
- R2: `reg_rdata[15:4]` always reads 0, whatever was written to those bits.
- R3: Power-on reset clears the register to 0x0000. So does a high level on `hw_stby` or `sw_stby` at a clock edge, and this clear wins over a write in the same cycle.
- R4: While `rst_man_n` is low, the register keeps its value and writes are ignored.
- R5: With the enable bit at 0, `map_addr` equals `cpu_addr` for every block number.
- R6: With the enable bit at 1 and block number k, addresses 0x0000_0000 + k*0x1000 through + 0xFFF map to 0xFFFF_0000 plus the low 12 address bits. Every other address passes through unchanged.
- R7: `fl_protect` is high exactly when the enable bit is 1 and `rom_en` is 1.
- R8: With `rom_en` low, no address is remapped and `fl_protect` stays low, whatever the register holds.
- R9: Addresses inside the RAM window (0xFFFF_0000 to 0xFFFF_0FFF) and addresses at or above 0x8000 are never remapped.
- R10: `fl_wr_reject` is high when `cpu_wr` is high, `fl_protect` is high, and the address is below the flash top (0x0004_0000) and is not remapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_por_n | input | 1 | Power-on reset, asynchronous active-low, released synchronously |
| rst_man_n | input | 1 | Manual reset, active-low; keeps the register and blocks writes |
| hw_stby | input | 1 | Hardware standby entry; clears the register |
| sw_stby | input | 1 | Software standby entry; clears the register |
| rom_en | input | 1 | On-chip ROM enabled mode |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |
| cpu_addr | input | 32 | CPU access address |
| cpu_wr | input | 1 | Access is a write |
| map_addr | output | 32 | Remapped address |
| fl_protect | output | 1 | Flash write/erase protect |
| fl_wr_reject | output | 1 | Write to protected flash detected |

## Verification
A register write and a standby clear can fall in the same clock cycle. The bench provokes this by raising `reg_wr` with an enabling value and `hw_stby` for one shared cycle. The result is judged after that edge: the read-back must be zero, `fl_protect` must be low, and a probe address inside the written block must pass through unremapped. A second collision holds `rst_man_n` low during a write and confirms that the earlier value stays both in the read-back and in the mapping.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  localparam int OVL_ADDR_W = 32;
  localparam int OVL_REG_W  = 16;
  localparam int OVL_IDX_W  = 3;
  localparam int OVL_BLK_W  = 12;
  localparam logic [OVL_ADDR_W-1:0] OVL_RAM_BASE  = 32'hFFFF_0000;
  localparam logic [OVL_ADDR_W-1:0] OVL_FLASH_TOP = 32'h0004_0000;

  typedef struct packed {
    logic                 en;
    logic [OVL_IDX_W-1:0] blk;
  } ovl_cfg_t;
endpackage

// File: rtl/ovl_rst_sync.sv
module ovl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/ovl_ctrl_reg.sv
module ovl_ctrl_reg
  import ovl_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     man_n,
  input  logic     clr,
  input  logic     wr,
  input  ovl_cfg_t wcfg,
  output ovl_cfg_t cfg
);
  ovl_cfg_t cfg_q;
  ovl_cfg_t cfg_d;
  logic     cfg_ld;

  // standby clear outranks a write; manual reset blocks writes only
  always_comb begin
    cfg_d  = cfg_q;
    cfg_ld = 1'b0;
    if (clr) begin
      cfg_d  = '0;
      cfg_ld = 1'b1;
    end else if (wr && man_n) begin
      cfg_d  = wcfg;
      cfg_ld = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_ld) cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/ovl_remap.sv
module ovl_remap
  import ovl_pkg::*;
#(
  parameter int                ADDR_W    = OVL_ADDR_W,
  parameter int                BLK_W     = OVL_BLK_W,
  parameter int                IDX_W     = OVL_IDX_W,
  parameter logic [ADDR_W-1:0] RAM_BASE  = OVL_RAM_BASE,
  parameter logic [ADDR_W-1:0] FLASH_TOP = OVL_FLASH_TOP
) (
  input  logic              en,
  input  logic [IDX_W-1:0]  blk,
  input  logic              rom_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              acc_wr,
  output logic [ADDR_W-1:0] addr_out,
  output logic              protect,
  output logic              wr_reject
);
  localparam int HI_LSB = BLK_W + IDX_W;

  logic eff_en;
  logic in_low;
  logic hit;
  logic in_flash;

  always_comb begin
    eff_en    = en & rom_en;
    in_low    = (addr[ADDR_W-1:HI_LSB] == '0);
    hit       = eff_en && in_low && (addr[HI_LSB-1:BLK_W] == blk);
    addr_out  = hit ? {RAM_BASE[ADDR_W-1:BLK_W], addr[BLK_W-1:0]} : addr;
    in_flash  = (addr < FLASH_TOP);
    protect   = eff_en;
    wr_reject = acc_wr && eff_en && in_flash && !hit;
  end
endmodule

// File: rtl/flash_ram_overlay.sv
module flash_ram_overlay
  import ovl_pkg::*;
#(
  parameter int                ADDR_W    = OVL_ADDR_W,
  parameter int                REG_W     = OVL_REG_W,
  parameter logic [ADDR_W-1:0] RAM_BASE  = OVL_RAM_BASE,
  parameter logic [ADDR_W-1:0] FLASH_TOP = OVL_FLASH_TOP
) (
  input  logic              clk,
  input  logic              rst_por_n,
  input  logic              rst_man_n,
  input  logic              hw_stby,
  input  logic              sw_stby,
  input  logic              rom_en,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  output logic [ADDR_W-1:0] map_addr,
  output logic              fl_protect,
  output logic              fl_wr_reject
);
  localparam int CFG_W = OVL_IDX_W + 1;

  logic     rst_s_n;
  ovl_cfg_t wcfg;
  ovl_cfg_t cfg;
  logic     unused_rsvd;

  assign wcfg        = ovl_cfg_t'(reg_wdata[CFG_W-1:0]);
  assign unused_rsvd = &{1'b0, reg_wdata[REG_W-1:CFG_W]};

  ovl_rst_sync #(.STAGES(2)) rst_i (
    .clk    (clk),
    .arst_n (rst_por_n),
    .srst_n (rst_s_n)
  );

  ovl_ctrl_reg ctrl_i (
    .clk   (clk),
    .rst_n (rst_s_n),
    .man_n (rst_man_n),
    .clr   (hw_stby | sw_stby),
    .wr    (reg_wr),
    .wcfg  (wcfg),
    .cfg   (cfg)
  );

  ovl_remap #(
    .ADDR_W    (ADDR_W),
    .BLK_W     (OVL_BLK_W),
    .IDX_W     (OVL_IDX_W),
    .RAM_BASE  (RAM_BASE),
    .FLASH_TOP (FLASH_TOP)
  ) remap_i (
    .en        (cfg.en),
    .blk       (cfg.blk),
    .rom_en    (rom_en),
    .addr      (cpu_addr),
    .acc_wr    (cpu_wr),
    .addr_out  (map_addr),
    .protect   (fl_protect),
    .wr_reject (fl_wr_reject)
  );

  assign reg_rdata = {{(REG_W-CFG_W){1'b0}}, cfg};
endmodule

// File: rtl/ovl_checker.sv
module ovl_checker #(
  parameter int                ADDR_W   = 32,
  parameter int                REG_W    = 16,
  parameter logic [ADDR_W-1:0] RAM_BASE = 32'hFFFF_0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_man_n,
  input logic              hw_stby,
  input logic              sw_stby,
  input logic              rom_en,
  input logic              reg_wr,
  input logic [REG_W-1:0]  reg_wdata,
  input logic [REG_W-1:0]  reg_rdata,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [ADDR_W-1:0] map_addr,
  input logic              fl_protect
);
  a_r1_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && rst_man_n && !hw_stby && !sw_stby) |=> (reg_rdata[3:0] == $past(reg_wdata[3:0])));

  a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[REG_W-1:4] == '0);

  a_r3_stby_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_stby || sw_stby) |=> (reg_rdata == '0));

  a_r4_man_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_man_n && !hw_stby && !sw_stby) |=> $stable(reg_rdata));

  a_r5_off_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[3] |-> (map_addr == cpu_addr));

  a_r7_protect: assert property (@(posedge clk) disable iff (!rst_n)
    fl_protect == (reg_rdata[3] && rom_en));

  a_r8_rom_off: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_en |-> (map_addr == cpu_addr && !fl_protect));

  a_r9_ram_window: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[ADDR_W-1:12] == RAM_BASE[ADDR_W-1:12]) |-> (map_addr == cpu_addr));

  a_r9_high_flash: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr >= 32'h0000_8000) |-> (map_addr == cpu_addr));
endmodule

bind flash_ram_overlay ovl_checker #(
  .ADDR_W   (ADDR_W),
  .REG_W    (REG_W),
  .RAM_BASE (RAM_BASE)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_s_n),
  .rst_man_n  (rst_man_n),
  .hw_stby    (hw_stby),
  .sw_stby    (sw_stby),
  .rom_en     (rom_en),
  .reg_wr     (reg_wr),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .cpu_addr   (cpu_addr),
  .map_addr   (map_addr),
  .fl_protect (fl_protect)
);

// File: tb/flash_ram_overlay_tb_top.sv
module flash_ram_overlay_tb_top;
  logic        clk = 1'b0;
  logic        rst_por_n, rst_man_n, hw_stby, sw_stby, rom_en;
  logic        reg_wr, cpu_wr;
  logic [15:0] reg_wdata, reg_rdata;
  logic [31:0] cpu_addr, map_addr;
  logic        fl_protect, fl_wr_reject;
  int          n_vec = 0;
  int          n_bad = 0;
  bit          done  = 1'b0;

  always #5 clk = ~clk;

  flash_ram_overlay dut_i (
    .clk(clk), .rst_por_n(rst_por_n), .rst_man_n(rst_man_n),
    .hw_stby(hw_stby), .sw_stby(sw_stby), .rom_en(rom_en),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .map_addr(map_addr),
    .fl_protect(fl_protect), .fl_wr_reject(fl_wr_reject)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_map(input logic [31:0] a, input logic [3:0] cfg, input logic rom);
    if (rom && cfg[3] && a < 32'h8000 && a[14:12] == cfg[2:0])
      return 32'hFFFF_0000 | {20'h0, a[11:0]};
    return a;
  endfunction

  task automatic wr_reg(input logic [15:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic probe(input string req, input logic [31:0] a, input logic [3:0] cfg);
    cpu_addr = a;
    #1;
    chk(req, map_addr, exp_map(a, cfg, rom_en));
  endtask

  task automatic do_por();
    @(negedge clk);
    rst_por_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_por_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    do_por();
    cpu_addr = 32'h0000_0123; #1;
    chk("R3 por rdata", {16'h0, reg_rdata}, 32'h0);
    chk("R7 por protect", {31'h0, fl_protect}, 32'h0);
    chk("R5 por map", map_addr, 32'h0000_0123);
    wr_reg(16'h000D);
    do_por();
    chk("R3 por clears written", {16'h0, reg_rdata}, 32'h0);
  endtask

  task automatic t_rsvd();
    wr_reg(16'hFFFF); #1;
    chk("R2 rsvd read", {16'h0, reg_rdata}, 32'h0000_000F);
    wr_reg(16'hA5F2); #1;
    chk("R1 low bits", {16'h0, reg_rdata}, 32'h0000_0002);
  endtask

  task automatic t_maps();
    wr_reg(16'h0005);
    probe("R5 en off", 32'h0000_5ABC, 4'h5);
    chk("R7 en off protect", {31'h0, fl_protect}, 32'h0);
    for (int k = 0; k < 8; k++) begin
      wr_reg(16'h0008 | 16'(k));
      probe("R6 hit", 32'(k) * 32'h1000 + 32'h123, 4'(8 + k));
      chk("R6 hit value", map_addr, 32'hFFFF_0123);
      probe("R6 neighbour", 32'(k ^ 1) * 32'h1000 + 32'h456, 4'(8 + k));
      chk("R7 protect on", {31'h0, fl_protect}, 32'h1);
    end
  endtask

  task automatic t_rom_off();
    wr_reg(16'h000B);
    rom_en = 1'b0;
    cpu_addr = 32'h0000_3010; #1;
    chk("R8 map", map_addr, 32'h0000_3010);
    chk("R8 protect", {31'h0, fl_protect}, 32'h0);
    rom_en = 1'b1; #1;
    chk("R6 rom back", map_addr, 32'hFFFF_0010);
  endtask

  task automatic t_bounds();
    wr_reg(16'h000F);
    probe("R6 top edge", 32'h0000_7FFF, 4'hF);
    chk("R6 top value", map_addr, 32'hFFFF_0FFF);
    probe("R6 low edge", 32'h0000_7000, 4'hF);
    chk("R6 low value", map_addr, 32'hFFFF_0000);
    probe("R9 0x8000", 32'h0000_8000, 4'hF);
    chk("R9 0x8000 pass", map_addr, 32'h0000_8000);
    probe("R6 below", 32'h0000_6FFF, 4'hF);
    cpu_addr = 32'hFFFF_0123; #1;
    chk("R9 ram window", map_addr, 32'hFFFF_0123);
    cpu_addr = 32'h1000_7123; #1;
    chk("R9 alias high", map_addr, 32'h1000_7123);
  endtask

  task automatic t_stby();
    wr_reg(16'h000C);
    @(negedge clk); hw_stby = 1'b1;
    @(negedge clk); hw_stby = 1'b0; #1;
    chk("R3 hw stby", {16'h0, reg_rdata}, 32'h0);
    wr_reg(16'h000E);
    @(negedge clk); sw_stby = 1'b1;
    @(negedge clk); sw_stby = 1'b0; #1;
    chk("R3 sw stby", {16'h0, reg_rdata}, 32'h0);
  endtask

  task automatic t_manual();
    wr_reg(16'h000A);
    @(negedge clk); rst_man_n = 1'b0;
    wr_reg(16'h0003);
    #1;
    chk("R4 man hold", {16'h0, reg_rdata}, 32'h0000_000A);
    probe("R4 man map", 32'h0000_2044, 4'hA);
    chk("R4 man map value", map_addr, 32'hFFFF_0044);
    @(negedge clk); rst_man_n = 1'b1;
    wr_reg(16'h0003); #1;
    chk("R1 after man", {16'h0, reg_rdata}, 32'h0000_0003);
  endtask

  task automatic t_reject();
    wr_reg(16'h0009);
    cpu_wr = 1'b1;
    cpu_addr = 32'h0000_2000; #1;
    chk("R10 flash write", {31'h0, fl_wr_reject}, 32'h1);
    cpu_addr = 32'h0000_1004; #1;
    chk("R10 remapped write", {31'h0, fl_wr_reject}, 32'h0);
    cpu_addr = 32'h2000_0000; #1;
    chk("R10 beyond flash", {31'h0, fl_wr_reject}, 32'h0);
    cpu_wr = 1'b0; cpu_addr = 32'h0000_2000; #1;
    chk("R10 read", {31'h0, fl_wr_reject}, 32'h0);
    wr_reg(16'h0001); cpu_wr = 1'b1; #1;
    chk("R10 unprotected", {31'h0, fl_wr_reject}, 32'h0);
    cpu_wr = 1'b0;
  endtask

  task automatic t_collide();
    wr_reg(16'h0000);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = 16'h000C; hw_stby = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; hw_stby = 1'b0;
    cpu_addr = 32'h0000_4100; #1;
    chk("R3 collide rdata", {16'h0, reg_rdata}, 32'h0);
    chk("R3 collide map", map_addr, 32'h0000_4100);
    chk("R7 collide protect", {31'h0, fl_protect}, 32'h0);
  endtask

  initial begin
    rst_por_n = 1'b0; rst_man_n = 1'b1; hw_stby = 1'b0; sw_stby = 1'b0;
    rom_en = 1'b1; reg_wr = 1'b0; reg_wdata = '0; cpu_addr = '0; cpu_wr = 1'b0;
    t_reset();
    t_rsvd();
    t_maps();
    t_rom_off();
    t_bounds();
    t_stby();
    t_manual();
    t_reject();
    t_collide();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule